// File: doc/BRIEF.md
# Block Memory Copy Engine

This block moves bytes from one memory location to another on behalf of a small 8-bit processor core. The core hands over a source pointer, a destination pointer, a 16-bit byte count, its current flag byte and the second byte of a prefixed opcode. The engine then walks memory through a simple synchronous read/write port. Each step reads the byte at the source address, writes it at the destination address one cycle later, moves both pointers one place up or down, and counts the byte count down by one.

Two opcode bits choose the variant. One bit sets the direction: ascending or descending addresses. The other bit chooses between a single transfer and a run that repeats until the count reaches zero. When the work is finished the engine returns the updated pointers, the count and the flag byte. It also reports how many machine cycles the instruction is charged, so the core can keep its timing account exact. Interrupt checks between repeated steps are left to the surrounding core.

Top module: `blkcopy_engine`

## Requirements
- R1: Bit 3 of `op_code` selects the direction (0 = ascending, 1 = descending) and bit 4 selects the mode (0 = one transfer, 1 = repeat). The four codes used are 0xA0, 0xA8, 0xB0 and 0xB8.
- R2: Each transfer drives one read cycle at the source address (`mem_rd_en`=1). The next cycle is a write cycle (`mem_wr_en`=1) at the destination address, carrying the byte the memory returned. Read and write enables are never high together.
- R3: After each transfer both pointers move by +1 (ascending) or −1 (descending), wrapping modulo 65536.
- R4: Each transfer lowers the count by one. A repeat run keeps transferring until the count becomes zero, so it ends with `cnt_out` = 0.
- R5: A repeat run started with a count of 0 performs 65536 transfers.
- R6: On completion, flag bit 4 (half carry) and flag bit 1 (subtract) are 0.
- R7: On completion, flag bit 2 (parity/overflow) is 1 for a single transfer whose count after decrement is nonzero, and 0 otherwise. A repeat run always leaves it 0.
- R8: Flag bits 7, 6, 5, 3 and 0 equal the values given in `flags_in` at start.
- R9: `cycles_out` is 16 for a single transfer. For a repeat run it is 16 + 5·N, where N is the starting count, or 65536 when that count is 0.
- R10: `busy` rises the cycle after a start is accepted and falls after the last write. `done` is a one-cycle pulse in the cycle after the last write, with the results valid. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| op_code | input | 8 | Opcode byte following the prefix |
| src_in | input | 16 | Starting source pointer |
| dst_in | input | 16 | Starting destination pointer |
| cnt_in | input | 16 | Starting byte count |
| flags_in | input | 8 | Flag byte at start |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the read strobe |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 16 | Updated source pointer |
| dst_out | output | 16 | Updated destination pointer |
| cnt_out | output | 16 | Updated count |
| flags_out | output | 8 | Updated flag byte |
| cycles_out | output | 20 | Machine cycles charged |

## Verification
The bench sweeps all four opcodes against counts 0, 1, 2 and 5 and three flag bytes. This separates direction errors, mode errors, wrong parity/overflow for count-after-decrement of zero versus nonzero, and flag bits leaking through. Overlapping source and destination ranges, with the destination one byte ahead in ascending mode, show whether each write really uses the byte just read, because the source pattern is overwritten as the run proceeds. Pointers placed at 0xFFFF and 0x0000 exercise wrap-around. A repeat run started at count zero shows the 65536-transfer case and its cycle charge.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
    // opcode bit positions decoded by the engine
    localparam int OPB_DIR = 3;
    localparam int OPB_REP = 4;
    // flag bit positions touched by the engine
    localparam int FLB_HALF = 4;
    localparam int FLB_PV   = 2;
    localparam int FLB_SUB  = 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } st_e;
endpackage

// File: rtl/blkcopy_decode.sv
module blkcopy_decode
    import blkcopy_pkg::*;
(
    input  logic [7:0] op_code,
    output logic       dec,
    output logic       rep
);
    always_comb begin
        dec = op_code[OPB_DIR];
        rep = op_code[OPB_REP];
    end
endmodule

// File: rtl/blkcopy_step.sv
module blkcopy_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         dec,
    output logic [W-1:0] nxt
);
    always_comb begin
        if (dec) nxt = val - W'(1);
        else     nxt = val + W'(1);
    end
endmodule

// File: rtl/blkcopy_cost.sv
module blkcopy_cost #(
    parameter int CNT_W    = 16,
    parameter int CYC_W    = 20,
    parameter int BASE_CYC = 16,
    parameter int ITER_CYC = 5
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             rep,
    output logic [CYC_W-1:0] cost
);
    localparam logic [CNT_W:0] FULL_RUN = {1'b1, {CNT_W{1'b0}}};

    logic [CNT_W:0] n_xfer;

    always_comb begin
        n_xfer = (cnt == '0) ? FULL_RUN : {1'b0, cnt};
        if (rep)
            cost = CYC_W'(BASE_CYC) + CYC_W'(ITER_CYC) * CYC_W'(n_xfer);
        else
            cost = CYC_W'(BASE_CYC);
    end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
    import blkcopy_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 16,
    parameter int FLAG_W   = 8,
    parameter int BASE_CYC = 16,
    parameter int ITER_CYC = 5,
    parameter int CYC_W    = CNT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        op_code,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] src_out,
    output logic [ADDR_W-1:0] dst_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [FLAG_W-1:0] flags_out,
    output logic [CYC_W-1:0]  cycles_out
);
    localparam int NPTR = 2;

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [FLAG_W-1:0] flags;
        logic [CYC_W-1:0]  cost;
        logic              dec;
        logic              rep;
        logic              done;
    } eng_t;

    eng_t eng_d, eng_q;

    logic              dec_in, rep_in;
    logic [CYC_W-1:0]  cost_in;
    logic [CNT_W-1:0]  cnt_m1;
    logic [ADDR_W-1:0] ptr_cur [NPTR];
    logic [ADDR_W-1:0] ptr_nxt [NPTR];

    blkcopy_decode u_dec (
        .op_code (op_code),
        .dec     (dec_in),
        .rep     (rep_in)
    );

    blkcopy_cost #(
        .CNT_W    (CNT_W),
        .CYC_W    (CYC_W),
        .BASE_CYC (BASE_CYC),
        .ITER_CYC (ITER_CYC)
    ) u_cost (
        .cnt  (cnt_in),
        .rep  (rep_in),
        .cost (cost_in)
    );

    assign ptr_cur[0] = eng_q.src;
    assign ptr_cur[1] = eng_q.dst;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        blkcopy_step #(.W(ADDR_W)) u_step (
            .val (ptr_cur[g]),
            .dec (eng_q.dec),
            .nxt (ptr_nxt[g])
        );
    end

    assign cnt_m1 = eng_q.cnt - CNT_W'(1);

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (start) begin
                    eng_d.st    = ST_READ;
                    eng_d.src   = src_in;
                    eng_d.dst   = dst_in;
                    eng_d.cnt   = cnt_in;
                    eng_d.flags = flags_in;
                    eng_d.cost  = cost_in;
                    eng_d.dec   = dec_in;
                    eng_d.rep   = rep_in;
                end
            end
            ST_READ: begin
                eng_d.st = ST_WRITE;
            end
            ST_WRITE: begin
                eng_d.src                = ptr_nxt[0];
                eng_d.dst                = ptr_nxt[1];
                eng_d.cnt                = cnt_m1;
                eng_d.flags[FLB_HALF]    = 1'b0;
                eng_d.flags[FLB_SUB]     = 1'b0;
                eng_d.flags[FLB_PV]      = !eng_q.rep && (cnt_m1 != '0);
                if (eng_q.rep && (cnt_m1 != '0)) begin
                    eng_d.st = ST_READ;
                end else begin
                    eng_d.st   = ST_IDLE;
                    eng_d.done = 1'b1;
                end
            end
            default: begin
                eng_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    always_comb begin
        mem_rd_en  = (eng_q.st == ST_READ);
        mem_wr_en  = (eng_q.st == ST_WRITE);
        mem_addr   = (eng_q.st == ST_WRITE) ? eng_q.dst : eng_q.src;
        mem_wdata  = mem_rdata;
        busy       = (eng_q.st != ST_IDLE);
        done       = eng_q.done;
        src_out    = eng_q.src;
        dst_out    = eng_q.dst;
        cnt_out    = eng_q.cnt;
        flags_out  = eng_q.flags;
        cycles_out = eng_q.cost;
    end
endmodule

// File: rtl/blkcopy_checker.sv
module blkcopy_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int FLAG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] src_out,
    input logic [CNT_W-1:0]  cnt_out,
    input logic [FLAG_W-1:0] flags_out
);
    p_rw_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en);

    p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));

    p_ptr_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (src_out == $past(src_out) + ADDR_W'(1)) ||
                      (src_out == $past(src_out) - ADDR_W'(1)));

    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> cnt_out == $past(cnt_out) - CNT_W'(1));

    p_hn_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flags_out[4] && !flags_out[1]));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

bind blkcopy_engine blkcopy_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .FLAG_W (FLAG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .busy      (busy),
    .done      (done),
    .src_out   (src_out),
    .cnt_out   (cnt_out),
    .flags_out (flags_out)
);

// File: tb/blkcopy_engine_test.sv
module blkcopy_engine_test;
    localparam int MAW  = 12;
    localparam int MSZ  = 1 << MAW;
    localparam int WDOG = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_code = 8'h00;
    logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
    logic [7:0]  flags_in = '0;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        busy, done;
    logic [15:0] src_out, dst_out, cnt_out;
    logic [7:0]  flags_out;
    logic [19:0] cycles_out;

    int n_run = 0;
    int n_fail = 0;
    int wr_seen = 0;
    logic reload = 1'b0;
    logic [7:0] mem   [MSZ];
    logic [7:0] model [MSZ];

    always #10 clk = ~clk;

    blkcopy_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .flags_in(flags_in),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
        .flags_out(flags_out), .cycles_out(cycles_out)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) ^ (i >> 5));
    endfunction

    always @(posedge clk) begin
        if (reload) begin
            for (int i = 0; i < MSZ; i++) mem[i] <= pat(i);
        end else if (mem_wr_en) begin
            mem[mem_addr[MAW-1:0]] <= mem_wdata;
        end
        if (mem_rd_en) mem_rdata <= mem[mem_addr[MAW-1:0]];
    end

    always @(negedge clk) if (mem_wr_en) wr_seen++;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [15:0] hl, input logic [15:0] de,
                          input logic [15:0] bc, input logic [7:0] fl, input bit poke);
        bit dec, rep;
        int n;
        logic [15:0] s, d, ecnt;
        logic [7:0] efl;
        int ecyc;
        bit mem_ok;
        dec = op[3];
        rep = op[4];
        // reload memory image in bench and model
        @(negedge clk) reload = 1'b1;
        @(negedge clk) reload = 1'b0;
        for (int i = 0; i < MSZ; i++) model[i] = pat(i);
        // expected result, R1 R3 R4 R5
        n = rep ? ((bc == 0) ? 65536 : int'(bc)) : 1;
        s = hl; d = de;
        for (int i = 0; i < n; i++) begin
            model[d[MAW-1:0]] = model[s[MAW-1:0]];
            s = dec ? s - 16'd1 : s + 16'd1;
            d = dec ? d - 16'd1 : d + 16'd1;
        end
        ecnt = rep ? 16'd0 : bc - 16'd1;
        efl  = (fl & 8'hE9) | ((!rep && ecnt != 0) ? 8'h04 : 8'h00);
        ecyc = rep ? 16 + 5 * n : 16;
        // launch
        wr_seen = 0;
        op_code = op; src_in = hl; dst_in = de; cnt_in = bc; flags_in = fl; start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy === 1'b1, "R10 busy after start", longint'(busy), 1);
        if (poke) begin
            @(negedge clk);
            op_code = 8'hA8; src_in = 16'h0123; dst_in = 16'h0456; cnt_in = 16'd9;
            flags_in = 8'h00; start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        chk(busy === 1'b0, "R10 idle at done", longint'(busy), 0);
        chk(src_out == s, "R3 source pointer", longint'(src_out), longint'(s));
        chk(dst_out == d, "R3 destination pointer", longint'(dst_out), longint'(d));
        chk(cnt_out == ecnt, "R4 count", longint'(cnt_out), longint'(ecnt));
        chk(wr_seen == n, "R5 transfer count", longint'(wr_seen), longint'(n));
        chk(flags_out[4] == 1'b0 && flags_out[1] == 1'b0, "R6 H and N clear",
            longint'(flags_out), longint'(efl));
        chk(flags_out[2] == efl[2], "R7 parity/overflow", longint'(flags_out[2]), longint'(efl[2]));
        chk((flags_out & 8'hE9) == (efl & 8'hE9), "R8 pass-through flags",
            longint'(flags_out), longint'(efl));
        chk(int'(cycles_out) == ecyc, "R9 cycle cost", longint'(cycles_out), longint'(ecyc));
        mem_ok = 1'b1;
        for (int i = 0; i < MSZ; i++) if (mem[i] !== model[i]) mem_ok = 1'b0;
        chk(mem_ok, "R2 memory image after copy (R1 opcode)", longint'(mem_ok), 1);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", longint'(done), 0);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  ops [4];
        logic [15:0] cnts [4];
        logic [7:0]  fls [3];
        ops  = '{8'hA0, 8'hA8, 8'hB0, 8'hB8};
        cnts = '{16'd0, 16'd1, 16'd2, 16'd5};
        fls  = '{8'h00, 8'hFF, 8'hA5};
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10 reset idle", longint'({busy, done}), 0);
        chk(mem_rd_en === 1'b0 && mem_wr_en === 1'b0, "R2 reset strobes",
            longint'({mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // sweep: opcode x count x flags (repeat with count 0 handled below)
        for (int o = 0; o < 4; o++)
            for (int c = 0; c < 4; c++)
                for (int f = 0; f < 3; f++)
                    if (!(ops[o][4] && cnts[c] == 0))
                        run_op(ops[o], 16'h0100 + 16'(o * 16), 16'h0800 + 16'(c * 32),
                               cnts[c], fls[f], 1'b0);
        // overlapping ranges: ascending fill, descending shift
        run_op(8'hB0, 16'h0200, 16'h0201, 16'd20, 8'h3C, 1'b0);
        run_op(8'hB8, 16'h0300, 16'h0302, 16'd17, 8'hC3, 1'b0);
        // wrap-around of both pointers
        run_op(8'hB0, 16'hFFFE, 16'h0FFD, 16'd4, 8'h00, 1'b0);
        run_op(8'hB8, 16'h0001, 16'h0002, 16'd3, 8'hFF, 1'b0);
        // start pulse while busy must be ignored (R10)
        run_op(8'hB0, 16'h0400, 16'h0600, 16'd12, 8'h81, 1'b1);
        // full 65536-transfer repeat run (R5)
        run_op(8'hB0, 16'h0010, 16'h0900, 16'd0, 8'h40, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule